// File: doc/BRIEF.md
# Write Completion Status Responder

This block answers host reads of a byte-wide non-volatile memory while the memory is busy storing data. While a page of bytes is being loaded or programmed, a host read does not return array contents. It returns a status byte instead. The byte reports three things: whether the cycle has finished, through an inverted copy of the last written data bit. It reports activity through a bit that alternates on each read. It also reports whether the byte-load window is still open. An active-low ready/busy line gives the same completion information without any bus reads.

The page write controller drives three inputs: a flag for the load window, a flag for the internal program cycle, and the last byte it accepted. The array drives the normal read data. The host strobes are active-low and are sampled on the block clock. High impedance is modelled as a per-bit drive enable. The ready/busy line is modelled as a plain active-low output rather than an open-drain pin.

Top module: `wr_status_resp`

## Requirements
- R1: All eight data bits are driven (dq_oe_o = 8'hFF in normal mode) only while ce_n_i = 0, oe_n_i = 0 and we_n_i = 1. With any other strobe combination dq_oe_o = 8'h00.
- R2: When neither busy_i nor load_run_i is set, a read returns array_data_i unchanged on dq_o.
- R3: In status mode (busy_i or load_run_i set), bit 7 of a read is the inverse of bit 7 of last_wr_i. Once status mode ends, bit 7 again shows the true array bit.
- R4: In status mode, bit 6 reads 0 on the first read and changes value after each completed read. A read is completed on the first clock edge at which the read condition of R1 has gone away.
- R5: Bit 6 restarts at 0 on every entry into status mode. As a result, the first read of each new cycle returns 0.
- R6: In status mode, bit 5 reads 0 while load_run_i is set and 1 when load_run_i is clear.
- R7: In a status read, bits 4..0 are not driven. dq_oe_o is then 8'hE0 (bits 7, 6 and 5 driven).
- R8: rdy_n_o is 1 after reset. It goes to 0 on the clock edge after busy_i rises and returns to 1 on the clock edge after busy_i falls.
- R9: Strobe patterns that are not a read, such as a write pulse or output enable without chip enable, do not advance bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Host chip enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| busy_i | input | 1 | Internal program cycle running |
| load_run_i | input | 1 | Byte-load window timer running |
| last_wr_i | input | DW | Last byte accepted by the write controller |
| array_data_i | input | DW | Array read data |
| dq_o | output | DW | Read data byte |
| dq_oe_o | output | DW | Per-bit drive enable (0 = high impedance) |
| rdy_n_o | output | 1 | Ready/busy, low while programming |

## Verification
The assertions assume that the host strobes and the controller flags are synchronous to clk_i and change only between edges. They also assume that status mode is entered before the host begins a read, so that a toggle restart never coincides with the end of a read. The bench changes every input on the falling clock edge. It raises busy_i or load_run_i at least one full cycle before it issues any read, and it holds each read for one full cycle so that the end of every read falls on its own edge.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned TIMER_BIT  = 5;
  localparam int unsigned STAT_BITS  = 3;
endpackage

// File: rtl/wsr_rd_detect.sv
module wsr_rd_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  output logic rd_act_o,
  output logic rd_end_o
);
  logic rd_q;

  assign rd_act_o = ~ce_n_i & ~oe_n_i & we_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_act_o;
  end

  assign rd_end_o = rd_q & ~rd_act_o;

  // R9: write strobe never reads as a read
  assert_write_not_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> !rd_act_o);
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic status_i,
  input  logic rd_end_i,
  output logic tgl_o
);
  logic status_q, tgl_q;
  logic start;

  assign start = status_i & ~status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      tgl_q    <= 1'b0;
    end else begin
      status_q <= status_i;
      if (start)                    tgl_q <= 1'b0;
      else if (status_i && rd_end_i) tgl_q <= ~tgl_q;
    end
  end

  assign tgl_o = tgl_q;

  assert_restart_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i) |=> (tgl_o == 1'b0));
  assert_flip_per_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i && status_q && rd_end_i) |=> (tgl_o != $past(tgl_o)));
  assert_hold_no_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && status_i && !rd_end_i) |=> $stable(tgl_o));
endmodule

// File: rtl/wsr_rb_drv.sv
module wsr_rb_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic rdy_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_n_o <= 1'b1;
    else         rdy_n_o <= ~busy_i;
  end

  assert_rb_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !rdy_n_o);
  assert_rb_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> rdy_n_o);
endmodule

// File: rtl/wsr_out_mux.sv
module wsr_out_mux
  import wsr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          rd_act_i,
  input  logic          status_i,
  input  logic          tgl_i,
  input  logic          load_run_i,
  input  logic [DW-1:0] last_wr_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] dq_oe_o
);
  localparam logic [DW-1:0] STAT_MASK = {{STAT_BITS{1'b1}}, {(DW-STAT_BITS){1'b0}}};

  always_comb begin
    dq_o    = array_data_i;
    dq_oe_o = '0;
    if (status_i) begin
      dq_o             = '0;
      dq_o[POLL_BIT]   = ~last_wr_i[POLL_BIT];
      dq_o[TOGGLE_BIT] = tgl_i;
      dq_o[TIMER_BIT]  = ~load_run_i;
    end
    if (rd_act_i) dq_oe_o = status_i ? STAT_MASK : '1;
  end

  always_comb begin
    if (!rd_act_i) assert_no_drive_R1: assert (dq_oe_o == '0);
    if (rd_act_i && status_i) assert_stat_oe_R7: assert (dq_oe_o[TIMER_BIT-1:0] == '0);
  end
endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic          busy_i,
  input  logic          load_run_i,
  input  logic [DW-1:0] last_wr_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] dq_oe_o,
  output logic          rdy_n_o
);
  logic rd_act, rd_end, tgl, status;

  assign status = busy_i | load_run_i;

  wsr_rd_detect u_rd (
    .clk_i, .rst_ni, .ce_n_i, .oe_n_i, .we_n_i,
    .rd_act_o(rd_act), .rd_end_o(rd_end)
  );

  wsr_toggle u_tgl (
    .clk_i, .rst_ni, .status_i(status), .rd_end_i(rd_end), .tgl_o(tgl)
  );

  wsr_rb_drv u_rb (
    .clk_i, .rst_ni, .busy_i, .rdy_n_o
  );

  wsr_out_mux #(.DW(DW)) u_mux (
    .rd_act_i(rd_act), .status_i(status), .tgl_i(tgl), .load_run_i,
    .last_wr_i, .array_data_i, .dq_o, .dq_oe_o
  );

  assert_poll_inv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && status) |-> (dq_o[7] == ~last_wr_i[7]));
  assert_idle_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && !status) |-> (dq_o == array_data_i && dq_oe_o == '1));
  assert_timer_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && status) |-> (dq_o[5] == !load_run_i));
endmodule

// File: tb/wr_status_resp_tb.sv
module wr_status_resp_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic busy = 1'b0, tmr = 1'b0;
  logic [7:0] last_wr = '0, arr = '0;
  logic [7:0] dq, dq_oe;
  logic rdy_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_status_resp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .busy_i(busy), .load_run_i(tmr), .last_wr_i(last_wr), .array_data_i(arr),
    .dq_o(dq), .dq_oe_o(dq_oe), .rdy_n_o(rdy_n)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] d, output logic [7:0] e);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); d = dq; e = dq_oe;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 reset rdy_n", {7'd0, rdy_n}, 8'h01);
    chk("R1 reset oe", dq_oe, 8'h00);
  endtask

  task automatic t_idle();
    logic [7:0] d, e;
    arr = 8'h3C;
    do_read(d, e);
    chk("R2 idle data", d, 8'h3C);
    chk("R1 idle oe", e, 8'hFF);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0;
    #1 chk("R1 we low oe", dq_oe, 8'h00);
    ce_n = 1; we_n = 1;
    #1 chk("R1 ce high oe", dq_oe, 8'h00);
    oe_n = 1;
  endtask

  task automatic t_poll();
    logic [7:0] d, e;
    @(negedge clk); tmr = 1; last_wr = 8'h80;
    @(negedge clk);
    do_read(d, e);
    chk("R3/R4/R6 load read", d[7:5], 3'b000);
    chk("R7 status oe", e, 8'hE0);
    tmr = 0; busy = 1;
    @(negedge clk);
    do_read(d, e);
    chk("R4 second read", {7'd0, d[6]}, 8'h01);
    chk("R6 timer expired", {7'd0, d[5]}, 8'h01);
    chk("R3 poll inverse", {7'd0, d[7]}, 8'h00);
    do_read(d, e);
    chk("R4 third read", {7'd0, d[6]}, 8'h00);
    busy = 0; arr = 8'h80;
    @(negedge clk);
    do_read(d, e);
    chk("R3 true after done", d, 8'h80);
    chk("R3 oe after done", e, 8'hFF);
  endtask

  task automatic t_rb();
    @(negedge clk); busy = 1;
    #1 chk("R8 not yet low", {7'd0, rdy_n}, 8'h01);
    @(negedge clk);
    chk("R8 low after edge", {7'd0, rdy_n}, 8'h00);
    busy = 0;
    @(negedge clk);
    chk("R8 released", {7'd0, rdy_n}, 8'h01);
  endtask

  task automatic t_restart();
    logic [7:0] d, e;
    @(negedge clk); busy = 1;
    @(negedge clk);
    do_read(d, e);
    chk("R5 first of cycle A", {7'd0, d[6]}, 8'h00);
    busy = 0;
    @(negedge clk); busy = 1;
    @(negedge clk);
    do_read(d, e);
    chk("R5 first of cycle B", {7'd0, d[6]}, 8'h00);
    busy = 0;
    @(negedge clk);
  endtask

  task automatic t_ignore();
    logic [7:0] d, e;
    @(negedge clk); busy = 1; last_wr = 8'h00;
    @(negedge clk);
    do_read(d, e);
    chk("R9 start", {7'd0, d[6]}, 8'h00);
    ce_n = 0; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1; oe_n = 0;
    @(negedge clk); oe_n = 1;
    @(negedge clk);
    do_read(d, e);
    chk("R9 no advance", {7'd0, d[6]}, 8'h01);
    chk("R3 poll inverse of 0", {7'd0, d[7]}, 8'h01);
    busy = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_idle();
    t_poll();
    t_rb();
    t_restart();
    t_ignore();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule